// File: doc/BRIEF.md
# Repeat-Mode ADC Conversion Sequencer

This block is the digital controller of a four-input analog-to-digital converter that converts one selected input over and over. Software sets up two small registers through a plain write port: a mode register whose bit 7 enables conversion, and a channel register whose two low bits pick the input. Once enabled, the sequencer runs a successive-approximation search. Each cycle it presents a trial code to the converter's DAC and reads back one comparator bit. After the last bit it stores the result and raises a one-cycle interrupt. It then begins the next conversion on the following cycle without any software action.

Any register write during a conversion abandons the conversion in progress. If the enable bit is still set after the write, the search restarts from the most significant bit with the new settings. If the write clears the enable bit, conversion stops at once. An abandoned conversion never updates the result and never raises the interrupt.

Top module: `adc_seq_ctrl`

## Requirements
- R1: A write with `wr_sel`=0 (mode register) and `wr_data[7]`=1 starts a conversion. In the cycle after the write edge, `busy` and `sar_start` are high and `trial` equals 1 shifted left by RES_W-1.
- R2: A write with `wr_sel`=1 (channel register) loads `wr_data[1:0]`, and `ch_sel` shows the new value from the next cycle. Conversions use the channel shown on `ch_sel`.
- R3: When a conversion completes, `result` takes the converted code and `irq` is high for exactly one cycle. `result_hi` always equals `result[9:2]`. `result` changes at no other time.
- R4: Each conversion takes RES_W cycles and works from the MSB down to the LSB. In each cycle, `trial` is the bits kept so far with the current bit set. `cmp_in`=1 at that cycle's closing edge keeps the bit, and `cmp_in`=0 clears it.
- R5: After a completion, the next conversion starts in the following cycle: `sar_start` is high and `busy` stays high. Conversions repeat until a register write intervenes.
- R6: A write to either register during a conversion, with the enable bit still 1 afterwards, aborts that conversion and restarts from the MSB in the next cycle. The aborted conversion produces no `irq` and no result update. This holds even when the write lands on the final bit's edge.
- R7: Writing the mode register with bit 7 = 0 during a conversion drives `busy` low in the next cycle and leaves `result` unchanged, with no `irq`.
- R8: While idle with the enable bit clear, a mode write with bit 7 = 0 or a channel write keeps `busy`, `trial`, `irq` and `result` unchanged.
- R9: `busy` is high from the first step of a conversion until completion or abort. While `busy` is low, `trial` is 0.
- R10: After reset, `result`, `result_hi`, `irq`, `busy`, `sar_start`, `trial` and `ch_sel` are all 0, and conversion is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Register select: 0 mode, 1 channel |
| wr_data | input | 8 | Write data (mode bit 7 = enable, channel bits 1:0) |
| cmp_in | input | 1 | Comparator: 1 when input is at or above `trial` |
| ch_sel | output | 2 | Selected analog input |
| sar_start | output | 1 | High in the first step of each conversion |
| trial | output | 10 | Trial code for the DAC |
| busy | output | 1 | Conversion in progress |
| result | output | 10 | Last completed conversion |
| result_hi | output | 8 | Upper eight bits of `result` |
| irq | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with its defaults: 10-bit results, a 2-bit channel index, an 8-bit write bus and enable at bit 7. An ideal comparator, modelled against a fixed level for each channel, lets the bench check every completed code against that level, including the extremes 0 and 1023. Short conversions of ten steps keep the run small. The bench sweeps a write across every step offset of a conversion, so it reaches the case where a write collides with the completion edge.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam int unsigned SAR_MAX_W = 16;

  typedef enum logic {
    REG_MODE = 1'b0,
    REG_CHAN = 1'b1
  } reg_sel_e;

  // trial code: bits already decided plus the bit under test
  function automatic logic [SAR_MAX_W-1:0] sar_trial(
    input logic [SAR_MAX_W-1:0] kept, input int unsigned step);
    return kept | (SAR_MAX_W'(1) << step);
  endfunction

  // decision on one bit: keep it when the comparator says input >= trial
  function automatic logic [SAR_MAX_W-1:0] sar_decide(
    input logic [SAR_MAX_W-1:0] kept, input int unsigned step, input logic keep);
    return keep ? (kept | (SAR_MAX_W'(1) << step)) : kept;
  endfunction

endpackage

// File: rtl/adc_cfg_regs.sv
module adc_cfg_regs
  import adc_seq_pkg::*;
#(
  parameter int unsigned REG_W  = 8,
  parameter int unsigned CH_W   = 2,
  parameter int unsigned EN_BIT = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [REG_W-1:0] wr_data,
  output logic [CH_W-1:0]  ch_q,
  output logic             restart,
  output logic             stop
);

  logic en_q;
  logic en_next;

  assign en_next = (reg_sel_e'(wr_sel) == REG_MODE) ? wr_data[EN_BIT] : en_q;
  assign restart = wr_en && en_next;
  assign stop    = wr_en && !en_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      ch_q <= '0;
    end else if (wr_en) begin
      if (reg_sel_e'(wr_sel) == REG_MODE) en_q <= wr_data[EN_BIT];
      else                                ch_q <= wr_data[CH_W-1:0];
    end
  end

endmodule

// File: rtl/adc_sar_engine.sv
module adc_sar_engine
  import adc_seq_pkg::*;
#(
  parameter int unsigned RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             stop,
  input  logic             cmp_in,
  output logic             busy,
  output logic             first_step,
  output logic [RES_W-1:0] trial,
  output logic             done,
  output logic [RES_W-1:0] done_code
);

  localparam int unsigned STEP_W = (RES_W > 1) ? $clog2(RES_W) : 1;
  localparam logic [STEP_W-1:0] MSB_STEP = STEP_W'(RES_W - 1);

  logic              busy_q;
  logic [STEP_W-1:0] step_q;
  logic [RES_W-1:0]  code_q;
  logic [RES_W-1:0]  decided;
  logic              last_step;

  assign decided    = RES_W'(sar_decide(SAR_MAX_W'(code_q), int'(step_q), cmp_in));
  assign last_step  = busy_q && (step_q == '0);
  assign done       = last_step && !restart && !stop;
  assign done_code  = decided;
  assign busy       = busy_q;
  assign first_step = busy_q && (step_q == MSB_STEP);
  assign trial      = busy_q ? RES_W'(sar_trial(SAR_MAX_W'(code_q), int'(step_q))) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      step_q <= MSB_STEP;
      code_q <= '0;
    end else if (restart) begin
      busy_q <= 1'b1;
      step_q <= MSB_STEP;
      code_q <= '0;
    end else if (stop) begin
      busy_q <= 1'b0;
      step_q <= MSB_STEP;
      code_q <= '0;
    end else if (busy_q) begin
      if (last_step) begin
        step_q <= MSB_STEP;
        code_q <= '0;
      end else begin
        step_q <= step_q - 1'b1;
        code_q <= decided;
      end
    end
  end

endmodule

// File: rtl/adc_result_store.sv
module adc_result_store #(
  parameter int unsigned RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done,
  input  logic [RES_W-1:0] done_code,
  output logic [RES_W-1:0] result,
  output logic             irq
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
      irq    <= 1'b0;
    end else begin
      irq <= done;
      if (done) result <= done_code;
    end
  end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int unsigned RES_W  = 10,
  parameter int unsigned CH_W   = 2,
  parameter int unsigned REG_W  = 8,
  parameter int unsigned EN_BIT = 7,
  parameter int unsigned HI_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [REG_W-1:0] wr_data,
  input  logic             cmp_in,
  output logic [CH_W-1:0]  ch_sel,
  output logic             sar_start,
  output logic [RES_W-1:0] trial,
  output logic             busy,
  output logic [RES_W-1:0] result,
  output logic [HI_W-1:0]  result_hi,
  output logic             irq
);

  // internal events brought out by name for the checker
  logic             ev_restart;
  logic             ev_stop;
  logic             ev_done;
  logic [RES_W-1:0] done_code;

  adc_cfg_regs #(.REG_W(REG_W), .CH_W(CH_W), .EN_BIT(EN_BIT)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ch_q(ch_sel), .restart(ev_restart), .stop(ev_stop)
  );

  adc_sar_engine #(.RES_W(RES_W)) u_sar (
    .clk(clk), .rst_n(rst_n), .restart(ev_restart), .stop(ev_stop), .cmp_in(cmp_in),
    .busy(busy), .first_step(sar_start), .trial(trial),
    .done(ev_done), .done_code(done_code)
  );

  adc_result_store #(.RES_W(RES_W)) u_res (
    .clk(clk), .rst_n(rst_n), .done(ev_done), .done_code(done_code),
    .result(result), .irq(irq)
  );

  assign result_hi = result[RES_W-1 -: HI_W];

endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
  parameter int unsigned RES_W  = 10,
  parameter int unsigned REG_W  = 8,
  parameter int unsigned EN_BIT = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             wr_sel,
  input logic [REG_W-1:0] wr_data,
  input logic             busy,
  input logic             sar_start,
  input logic [RES_W-1:0] trial,
  input logic [RES_W-1:0] result,
  input logic             irq,
  input logic             ev_restart,
  input logic             ev_done
);

  assert_enable_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel && wr_data[EN_BIT]) |=> (busy && sar_start));

  assert_irq_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  assert_result_only_on_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> irq);

  assert_repeat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_done && !wr_en) |=> (busy && sar_start && irq));

  assert_abort_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ev_restart) |=> (sar_start && !irq));

  assert_stop_now_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel && !wr_data[EN_BIT]) |=> (!busy && !irq));

  assert_idle_trial_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (trial == '0));

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.RES_W(RES_W), .REG_W(REG_W), .EN_BIT(EN_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .busy(busy), .sar_start(sar_start), .trial(trial), .result(result), .irq(irq),
  .ev_restart(ev_restart), .ev_done(ev_done)
);

// File: tb/adc_seq_ctrl_tb.sv
`timescale 1ns/1ps
module adc_seq_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       cmp_in;
  logic [1:0] ch_sel;
  logic       sar_start;
  logic [9:0] trial;
  logic       busy;
  logic [9:0] result;
  logic [7:0] result_hi;
  logic       irq;

  int n_chk = 0;
  int n_err = 0;
  int lvl [4] = '{100, 677, 300, 1023};

  always #2.5 clk = ~clk;

  // ideal comparator against the level of the selected input
  assign cmp_in = (int'(trial) <= lvl[ch_sel]);

  adc_seq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cmp_in(cmp_in), .ch_sel(ch_sel), .sar_start(sar_start), .trial(trial),
    .busy(busy), .result(result), .result_hi(result_hi), .irq(irq)
  );

  // behavioural reference
  int m_en = 0, m_ch = 0, m_busy = 0, m_step = 9, m_code = 0, m_res = 0, m_irq = 0;
  int cmp_s = 0;
  int irq_count = 0;

  always @(posedge clk) begin
    if (rst_n) begin
      m_irq = 0;
      if (wr_en) begin
        if (wr_sel == 1'b0) m_en = wr_data[7];
        else                m_ch = int'(wr_data[1:0]);
        if (m_en != 0) begin m_busy = 1; m_step = 9; m_code = 0; end
        else m_busy = 0;
      end else if (m_busy != 0) begin
        if (cmp_s != 0) m_code = m_code + (1 << m_step);
        if (m_step == 0) begin
          m_res = m_code; m_irq = 1; m_step = 9; m_code = 0;
          irq_count++;
        end else m_step--;
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 ch_sel", int'(ch_sel), m_ch);
      chk("R9 busy", int'(busy), m_busy);
      chk("R4 trial", int'(trial), (m_busy != 0) ? (m_code + (1 << m_step)) : 0);
      chk("R1/R5 sar_start", int'(sar_start), (m_busy != 0 && m_step == 9) ? 1 : 0);
      chk("R3 result", int'(result), m_res);
      chk("R3 result_hi", int'(result_hi), m_res >> 2);
      chk("R3 irq", int'(irq), m_irq);
    end
    cmp_s = int'(cmp_in);
  end

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    wr_sel = sel; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #200000us;
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    int ic;
    int r_hold;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 result", int'(result), 0);
    chk("R10 busy", int'(busy), 0);
    chk("R10 irq", int'(irq), 0);
    chk("R10 trial", int'(trial), 0);
    chk("R10 ch_sel", int'(ch_sel), 0);
    rst_n = 1'b1;
    idle(2);

    // R8 writes while disabled do nothing to the sequencer
    wr(1'b1, 8'h01);
    wr(1'b0, 8'h7F);
    idle(3);
    chk("R8 busy idle", int'(busy), 0);
    chk("R8 result idle", int'(result), 0);
    chk("R2 channel loaded", int'(ch_sel), 1);

    // R1 start, R3 and R5 repeated conversions on channel 1
    wr(1'b0, 8'h80);
    idle(10);
    chk("R3 first code", int'(result), lvl[1]);
    ic = irq_count;
    idle(20);
    chk("R5 repeated completions", irq_count - ic, 2);

    // R6 channel write part way through
    idle(4);
    wr(1'b1, 8'h02);
    idle(11);
    chk("R6 code after channel change", int'(result), lvl[2]);

    // R6 mode rewrite part way through, then writes at every step offset
    idle(3);
    wr(1'b0, 8'h80);
    for (int off = 0; off < 12; off++) begin
      idle(off);
      wr(1'b1, 8'(off % 4));
    end
    idle(12);

    // R4 extremes: level 0 and full scale
    wr(1'b1, 8'h00);
    lvl[0] = 0;
    idle(11);
    chk("R4 zero code", int'(result), 0);
    wr(1'b1, 8'h03);
    idle(11);
    chk("R4 full scale code", int'(result), 1023);
    chk("R3 high view", int'(result_hi), 255);

    // R7 stop part way through
    idle(5);
    r_hold = int'(result);
    wr(1'b0, 8'h00);
    chk("R7 busy after stop", int'(busy), 0);
    idle(20);
    chk("R7 result kept", int'(result), r_hold);

    // R8 channel write while stopped
    wr(1'b1, 8'h01);
    idle(12);
    chk("R8 no restart", int'(busy), 0);
    chk("R8 result unchanged", int'(result), r_hold);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule